// File: doc/BRIEF.md
# Framed-Select SPI Master

This block is a byte-wide SPI bus master driven through eight small registers. Software loads outgoing bytes into a 16-entry transmit queue. Each queued byte carries one extra tag bit that marks it as the last byte of a frame. A shift engine takes bytes from the queue and moves them over the serial lines, with a serial clock derived from the module clock by a 16-bit divisor. The bytes it receives go into a 16-entry receive queue, which software drains by reading a data register.

Slave select is framed rather than pulsed. When frame mode is on, select goes low with the first byte and stays low over every following byte. It also stays low while the engine waits on an empty queue. It rises only after the tagged byte has fully shifted. When frame mode is off, select rises after every byte. Clock polarity, clock phase and bit order are set independently. A transmit-empty event and a receive-overflow event each latch a status bit, and each status bit can be masked onto the interrupt line.

Top module: `spi_frame_master`

## Requirements
- R1: After reset, ss_n is 1, sck is 0, irq is 0, and both the transmitter and the receiver are disabled. The mode register reads 0. The divisor register reads the default divisor CLK_HZ/1 MHz - 1 (99 at the default parameters), with its low byte in bits 23:16 and its high byte in bits 15:8.
- R2: The divisor is written at address 1: bits 23:16 hold the low byte and bits 15:8 hold the high byte. Each bit slot lasts divisor+1 module clocks, so SCK runs at the module clock / (divisor+1). A divisor of 0 acts as 1.
- R3: The mode register is at address 0. Bit 0 is CPHA, bit 1 is CPOL, bit 2 selects LSB-first and bit 3 enables frame mode. SCK rests at the CPOL level whenever no byte is shifting.
- R4: With CPHA=0, MISO is sampled on the first SCK edge of each bit and MOSI changes on the second edge. With CPHA=1 the roles of the two edges swap. Bytes go out and come in MSB-first unless LSB-first is set.
- R5: In frame mode, ss_n stays low across consecutive bytes and while the transmit queue is empty. It rises only once a byte tagged end-of-frame has completed. Without frame mode, ss_n rises after every byte.
- R6: Writing address 3 queues bits 7:0 as data and bit 8 as the end-of-frame tag. The queue holds 16 entries, and a write to a full queue is dropped. While the transmitter is disabled, no byte starts.
- R7: Address 5 reads the levels: the receive count in bits 4:0, the transmit count in bits 12:8, and a size field in bits 26:16 equal to the depth divided by 4. Each read of address 4 returns the oldest received byte and removes it.
- R8: A byte that completes while the receive queue is full is discarded, and status bit 1 is set. Status bit 1 stays set until a 1 is written to it at address 6, or until a receiver reset.
- R9: Status bit 0 at address 6 is set when the engine takes the last byte out of the transmit queue, and writing a 1 to it clears it. irq is high exactly when a status bit is set together with its mask bit at address 7.
- R10: Command writes go to address 2. Bit 0 resets the receiver: it empties the receive queue and clears the overflow bit. Bit 1 resets the transmitter: it empties the transmit queue, aborts the current byte and raises ss_n. Bits 2 and 3 enable and disable the transmitter, and bits 4 and 5 do the same for the receiver. While the receiver is disabled, received bytes are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at address 4) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |

## Verification
The bench sweeps every combination of polarity, phase and bit order at divisors 0 to 3. It decodes MOSI on the bench's own sample edges and compares the result with the bytes it queued. A design that swapped the capture edge, or reversed the bit order, would produce bytes that do not match. The bench also counts the low cycles of select and the spacing between SCK edges, which catches an off-by-one in the divisor and a select that drops between the bytes of a frame. Directed cases cover:
- a full receive queue: the overflow must keep the old bytes;
- a frame with no end-of-frame tag: select must stay low and SCK must rest at CPOL;
- writes to a full transmit queue;
- the disable and reset commands;
- the write-one-to-clear status bits and their masks.

// File: rtl/spi_frame_master.sv
module spi_frame_master #(
  parameter int CLK_HZ = 100_000_000,
  parameter int DEPTH  = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        sck,
  output logic        mosi,
  input  logic        miso,
  output logic        ss_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [15:0] DIV_RST = 16'(CLK_HZ / 1_000_000 - 1);
  localparam logic [10:0] SZ_FIELD = 11'(DEPTH / 4);

  logic cpha, cpol, lsb, frame_en, tx_en, rx_en;
  logic [15:0] div;
  logic [1:0] stat, mask;

  logic [8:0] txm [DEPTH];
  logic [7:0] rxm [DEPTH];
  logic [AW-1:0] twp, trp, rwp, rrp;
  logic [CW-1:0] tcnt, rcnt;

  logic busy, cur_eof, sck_act, mosi_q, ss_q;
  logic [15:0] cnt;
  logic [2:0] bitn;
  logic [7:0] txb, rxs, tx_ord, rx_raw, rx_byte;

  logic unused_bits;
  assign unused_bits = ^reg_wdata[31:24];

  logic wr_cmd, wr_stat, tx_rst, rx_rst, tx_push, tx_pop, rx_push, rx_pop, ovf_evt, empty_evt;
  logic start, lead, trail, done;
  logic [15:0] dv, half;

  assign wr_cmd  = reg_wr && reg_addr == 3'd2;
  assign wr_stat = reg_wr && reg_addr == 3'd6;
  assign tx_rst  = wr_cmd && reg_wdata[1];
  assign rx_rst  = wr_cmd && reg_wdata[0];

  assign dv    = (div == 16'd0) ? 16'd1 : div;
  assign half  = dv >> 1;
  assign start = !busy && tx_en && tcnt != '0 && !tx_rst;
  assign lead  = busy && cnt == half;
  assign trail = busy && cnt == dv;
  assign done  = trail && bitn == 3'd7;

  assign tx_push   = reg_wr && reg_addr == 3'd3 && tcnt != FULL && !tx_rst;
  assign tx_pop    = start;
  assign empty_evt = tx_pop && tcnt == CW'(1) && !tx_push;
  assign rx_push   = done && rx_en && !rx_rst && rcnt != FULL;
  assign ovf_evt   = done && rx_en && !rx_rst && rcnt == FULL;
  assign rx_pop    = reg_rd && reg_addr == 3'd4 && rcnt != '0 && !rx_rst;

  always_comb begin
    rx_raw = cpha ? {rxs[6:0], miso} : rxs;
    for (int i = 0; i < 8; i++) begin
      tx_ord[i]  = lsb ? txm[trp][7-i] : txm[trp][i];
      rx_byte[i] = lsb ? rx_raw[7-i] : rx_raw[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cpha, cpol, lsb, frame_en, tx_en, rx_en} <= '0;
      div <= DIV_RST;
      stat <= '0;
      mask <= '0;
    end else begin
      if (reg_wr && reg_addr == 3'd0) {frame_en, lsb, cpol, cpha} <= reg_wdata[3:0];
      if (reg_wr && reg_addr == 3'd1) div <= {reg_wdata[15:8], reg_wdata[23:16]};
      if (reg_wr && reg_addr == 3'd7) mask <= reg_wdata[1:0];
      if (wr_cmd && reg_wdata[2]) tx_en <= 1'b1;
      if (wr_cmd && reg_wdata[3]) tx_en <= 1'b0;
      if (wr_cmd && reg_wdata[4]) rx_en <= 1'b1;
      if (wr_cmd && reg_wdata[5]) rx_en <= 1'b0;
      stat[0] <= (stat[0] && !(wr_stat && reg_wdata[0])) || empty_evt;
      stat[1] <= !rx_rst && ((stat[1] && !(wr_stat && reg_wdata[1])) || ovf_evt);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      twp <= '0; trp <= '0; tcnt <= '0;
      rwp <= '0; rrp <= '0; rcnt <= '0;
    end else begin
      if (tx_rst) begin
        twp <= '0; trp <= '0; tcnt <= '0;
      end else begin
        if (tx_push) twp <= twp + AW'(1);
        if (tx_pop) trp <= trp + AW'(1);
        tcnt <= tcnt + CW'(tx_push) - CW'(tx_pop);
      end
      if (rx_rst) begin
        rwp <= '0; rrp <= '0; rcnt <= '0;
      end else begin
        if (rx_push) rwp <= rwp + AW'(1);
        if (rx_pop) rrp <= rrp + AW'(1);
        rcnt <= rcnt + CW'(rx_push) - CW'(rx_pop);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) txm[twp] <= reg_wdata[8:0];
    if (rx_push) rxm[rwp] <= rx_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cur_eof <= 1'b0; sck_act <= 1'b0; mosi_q <= 1'b0; ss_q <= 1'b1;
      cnt <= '0; bitn <= '0; txb <= '0; rxs <= '0;
    end else if (tx_rst) begin
      busy <= 1'b0; sck_act <= 1'b0; ss_q <= 1'b1;
    end else if (start) begin
      busy <= 1'b1; cnt <= '0; bitn <= '0; sck_act <= 1'b0; ss_q <= 1'b0;
      txb <= tx_ord; cur_eof <= txm[trp][8]; mosi_q <= tx_ord[7];
    end else if (busy) begin
      cnt <= (cnt == dv) ? 16'd0 : cnt + 16'd1;
      if (lead) begin
        sck_act <= 1'b1;
        if (!cpha) rxs <= {rxs[6:0], miso};
        else mosi_q <= txb[3'd7 - bitn];
      end
      if (trail) begin
        sck_act <= 1'b0;
        bitn <= bitn + 3'd1;
        if (cpha) rxs <= {rxs[6:0], miso};
        else if (bitn != 3'd7) mosi_q <= txb[3'd6 - bitn];
        if (bitn == 3'd7) begin
          busy <= 1'b0;
          if (!frame_en || cur_eof) ss_q <= 1'b1;
        end
      end
    end
  end

  assign sck  = sck_act ^ cpol;
  assign mosi = mosi_q;
  assign ss_n = ss_q;
  assign irq  = |(stat & mask);

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = {28'd0, frame_en, lsb, cpol, cpha};
      3'd1: reg_rdata = {8'd0, div[7:0], div[15:8], 8'd0};
      3'd2: reg_rdata = {30'd0, rx_en, tx_en};
      3'd4: reg_rdata = (rcnt != '0) ? {24'd0, rxm[rrp]} : 32'd0;
      3'd5: reg_rdata = (32'(SZ_FIELD) << 16) | (32'(tcnt) << 8) | 32'(rcnt);
      3'd6: reg_rdata = {30'd0, stat};
      3'd7: reg_rdata = {30'd0, mask};
      default: reg_rdata = 32'd0;
    endcase
  end

  AST_SS_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !ss_q); // R5
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && frame_en && !cur_eof && !tx_rst) |=> !ss_q); // R5
  AST_TX_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n) tcnt <= FULL); // R6
  AST_RX_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n) rcnt <= FULL); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[1] && !rx_rst && !(wr_stat && reg_wdata[1])) |=> stat[1]); // R8
  AST_SCK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != half && cnt != dv && !tx_rst) |=> $stable(sck_act)); // R2
endmodule

// File: tb/test_spi_frame_master.sv
module test_spi_frame_master;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq, sck, mosi, miso, ss_n;
  logic inv = 1'b0;

  assign miso = mosi ^ inv;
  always #(CLK_PERIOD/2) clk = ~clk;

  spi_frame_master i_spi_frame_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_n(ss_n));

  int checks = 0, errors = 0;
  bit finished = 0;

  logic b_cpol = 0, b_cpha = 0, b_lsb = 0;
  logic prev_sck = 0, prev_ss = 1;
  logic [7:0] sr = 0;
  int nb = 0, mon_n = 0, rises = 0, lowcyc = 0, cyc = 0, last_lead = -1000, gap_min = 1000;
  logic [7:0] mon_q [0:63];

  function automatic logic [7:0] rev8(input logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = x[7-i];
    return r;
  endfunction

  always @(negedge clk) begin
    logic is_lead, is_trail, smp;
    logic [7:0] nsr;
    cyc++;
    is_lead  = (prev_sck == b_cpol) && (sck != b_cpol);
    is_trail = (prev_sck != b_cpol) && (sck == b_cpol);
    smp = b_cpha ? is_trail : is_lead;
    if (is_lead) begin
      if (cyc - last_lead < gap_min) gap_min = cyc - last_lead;
      last_lead = cyc;
    end
    if (smp) begin
      nsr = {sr[6:0], mosi};
      sr = nsr;
      nb++;
      if (nb == 8) begin
        if (mon_n < 64) mon_q[mon_n] = b_lsb ? rev8(nsr) : nsr;
        mon_n++;
        nb = 0;
      end
    end
    if (ss_n && !prev_ss) rises++;
    if (!ss_n) lowcyc++;
    prev_sck = sck;
    prev_ss = ss_n;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic mon_clear();
    @(negedge clk);
    #1;
    nb = 0; mon_n = 0; rises = 0; lowcyc = 0; gap_min = 1000; last_lead = -1000;
  endtask

  task automatic set_mode(input logic fr, input logic l, input logic po, input logic ph, input int d);
    b_cpol = po; b_cpha = ph; b_lsb = l;
    wr(3'd0, {28'd0, fr, l, po, ph});
    wr(3'd1, {8'd0, 8'(d), 8'(d >> 8), 8'd0});
    mon_clear();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] vals [0:2];
    int cfg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ss_n", 32'(ss_n), 1);
    chk("R1 sck", 32'(sck), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(3'd1, v); chk("R1 divisor default", v, 32'h0063_0000);
    rd(3'd0, v); chk("R1 mode", v, 0);
    rd(3'd2, v); chk("R1 enables", v, 0);
    rd(3'd5, v); chk("R7 size field", 32'(v[26:16]) * 4, 16);

    wr(3'd2, 32'h14);
    cfg = 0;
    // R2 R3 R4 R5 R7 sweep
    for (int po = 0; po < 2; po++)
      for (int ph = 0; ph < 2; ph++)
        for (int l = 0; l < 2; l++)
          for (int d = 0; d < 4; d++) begin
            int dv;
            dv = (d == 0) ? 1 : d;
            inv = cfg[0];
            set_mode(1'b1, 1'(l), 1'(po), 1'(ph), d);
            for (int k = 0; k < 3; k++) begin
              vals[k] = 8'((8'h3C + cfg * 29 + k * 71) & 8'hFF);
              wr(3'd3, {23'd0, (k == 2), vals[k]});
            end
            repeat (3 * (8 * (dv + 1) + 1) + 20) @(negedge clk);
            chk("R4 byte count", mon_n, 3);
            for (int k = 0; k < 3; k++) chk("R4 mosi byte", 32'(mon_q[k]), 32'(vals[k]));
            chk("R5 one release", rises, 1);
            chk("R5 select low span", lowcyc, 24 * (dv + 1) + 2);
            chk("R2 bit period", gap_min, dv + 1);
            chk("R3 sck rest", 32'(sck), po);
            rd(3'd5, v); chk("R7 rx level", 32'(v[4:0]), 3);
            for (int k = 0; k < 3; k++) begin
              rd(3'd4, v);
              chk("R7 rx pop", v, 32'(vals[k] ^ (inv ? 8'hFF : 8'h00)));
            end
            rd(3'd5, v); chk("R7 rx drained", 32'(v[4:0]), 0);
            cfg++;
          end
    inv = 1'b0;

    // R5 no frame mode
    set_mode(1'b0, 1'b0, 1'b0, 1'b0, 1);
    wr(3'd3, 32'h011); wr(3'd3, 32'h022);
    repeat (60) @(negedge clk);
    chk("R5 per-byte release", rises, 2);
    // R5 frame without tag
    set_mode(1'b1, 1'b0, 1'b0, 1'b0, 1);
    wr(3'd3, 32'h055);
    repeat (60) @(negedge clk);
    chk("R5 held without eof", 32'(ss_n), 0);
    chk("R5 sck rests at cpol", 32'(sck), 0);
    chk("R5 no release", rises, 0);
    wr(3'd3, 32'h1AA);
    repeat (60) @(negedge clk);
    chk("R5 release after eof", rises, 1);
    chk("R4 two bytes", mon_n, 2);
    chk("R4 second byte", 32'(mon_q[1]), 32'hAA);
    // R10 rx reset
    rd(3'd5, v); chk("R7 rx level before reset", 32'(v[4:0]), 4);
    wr(3'd2, 32'h01);
    rd(3'd5, v); chk("R10 rx reset flush", 32'(v[4:0]), 0);

    // R9 tx empty
    wr(3'd6, 32'h3); wr(3'd7, 32'h0);
    wr(3'd3, 32'h17E);
    repeat (40) @(negedge clk);
    rd(3'd6, v); chk("R9 empty status", 32'(v[0]), 1);
    chk("R9 masked irq", 32'(irq), 0);
    wr(3'd7, 32'h1);
    chk("R9 unmasked irq", 32'(irq), 1);
    wr(3'd6, 32'h1);
    rd(3'd6, v); chk("R9 w1c", 32'(v[0]), 0);
    chk("R9 irq cleared", 32'(irq), 0);
    wr(3'd7, 32'h0);
    wr(3'd2, 32'h01);

    // R8 overflow
    for (int k = 0; k < 16; k++) wr(3'd3, {23'd0, (k == 15), 8'(k * 13 + 1)});
    repeat (16 * 17 + 30) @(negedge clk);
    wr(3'd3, 32'h0F0); wr(3'd3, 32'h10F);
    repeat (60) @(negedge clk);
    rd(3'd5, v); chk("R8 rx full level", 32'(v[4:0]), 16);
    rd(3'd6, v); chk("R8 overflow set", 32'(v[1]), 1);
    rd(3'd4, v); chk("R8 old data kept", v, 32'd1);
    wr(3'd3, 32'h100);
    repeat (40) @(negedge clk);
    rd(3'd6, v); chk("R8 still sticky", 32'(v[1]), 1);
    wr(3'd6, 32'h2);
    rd(3'd6, v); chk("R8 w1c", 32'(v[1]), 0);
    wr(3'd2, 32'h01);

    // R6 R10 tx disabled, full queue, tx reset
    mon_clear();
    wr(3'd2, 32'h08);
    for (int k = 0; k < 18; k++) wr(3'd3, {23'd0, 1'b1, 8'(k)});
    repeat (40) @(negedge clk);
    rd(3'd5, v); chk("R6 tx cap", 32'(v[12:8]), 16);
    chk("R6 disabled no start", mon_n, 0);
    chk("R6 select idle", 32'(ss_n), 1);
    wr(3'd2, 32'h02);
    rd(3'd5, v); chk("R10 tx reset flush", 32'(v[12:8]), 0);
    wr(3'd2, 32'h04);
    repeat (40) @(negedge clk);
    chk("R10 nothing after flush", mon_n, 0);

    // R10 rx disabled
    wr(3'd2, 32'h20);
    wr(3'd3, 32'h1C3);
    repeat (40) @(negedge clk);
    chk("R10 byte still sent", mon_n, 1);
    rd(3'd5, v); chk("R10 rx discarded", 32'(v[4:0]), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule